// File: doc/BRIEF.md
# Interrupt Acknowledge Hold Controller

This block sits beside the retire stage of a small in-order CPU and decides, at every instruction boundary, whether a pending maskable interrupt is taken. Each retiring instruction is reported by a strobe and a 4-bit class tag. Some classes delay acknowledgment. These are writes to the status word, the two returns, interrupt enable and disable, conditional skips, and writes to the interrupt flag, mask or priority registers. When one of them retires, its boundary is skipped and at least one more instruction runs before any request can be taken. A software break is not a delaying class. Instead it makes the block request that the global enable be cleared, and nothing is acknowledged at its boundary.

The request flags, mask bits, priority fields and global enable live outside the block and arrive as plain inputs. When an eligible request wins, the block raises a one-cycle acknowledge. In that same cycle it drives a one-hot clear for the winner's flag and a clear for the global enable. The owner of those registers applies both clears at the next clock edge. The block then offers the winning source index on a valid/ready stream toward the status-word and program-counter save logic, which vectors to the service routine.

The stream follows these back-pressure rules. Once `svc_valid_o` is high, it and `svc_src_o` stay unchanged until a cycle in which `svc_ready_i` is high. The transfer completes on that edge. While a transfer is outstanding, no new request is acknowledged, and boundaries that pass in that time are lost for acknowledgment.

Top module: `irq_ack_hold_ctrl`

## Requirements
- R1: After reset, `ack_o`, `ie_clr_o`, `svc_valid_o` and every bit of `flag_clr_o` are 0, and the first boundary after reset is not held.
- R2: Class codes 1 to 7 are delaying classes: 1 status-word write, 2 return from interrupt, 3 return from break, 4 enable, 5 disable, 6 skip, 7 interrupt-register write. No request is acknowledged at the boundary of an instruction with one of these codes.
- R3: At the boundary of a non-delaying instruction that retires after a delaying one, a pending eligible request is acknowledged. Consecutive delaying instructions keep suppressing acknowledgment until a non-delaying one retires.
- R4: A source is eligible only when its flag is 1, its mask bit is 0 and `ie_i` is 1.
- R5: Among eligible sources, the lowest priority field value wins, and on equal values the lowest index wins. Source i's priority field is `pri_i[i*PRI_W +: PRI_W]`.
- R6: A boundary is the cycle after a cycle in which `retire_valid_i` is high. When a request is taken, `ack_o` is high for that one cycle. In that cycle `ack_src_o` gives the winner, `flag_clr_o` has exactly the winner's bit set, and `ie_clr_o` is high.
- R7: Class code 8 (software break) is not delaying. At its boundary `ie_clr_o` is high and `ack_o` is low.
- R8: `svc_valid_o` rises in the cycle after `ack_o` and carries the winner in `svc_src_o`. Both hold steady until `svc_ready_i` is high. While `svc_valid_o` is high, `ack_o` stays low.
- R9: A request that becomes eligible while a hold is in force stays pending. It is acknowledged at the first boundary that is not held.
- R10: Without a retire strobe there is no boundary, and `ack_o` stays low even with eligible requests.
- R11: Class code 0 and codes 9 to 15 are ordinary instructions and allow acknowledgment at their boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retire_valid_i | input | 1 | An instruction retires this cycle |
| retire_cls_i | input | 4 | Class tag of the retiring instruction |
| flags_i | input | N_SRC | Interrupt request flags |
| mask_i | input | N_SRC | Mask bits, 1 blocks the source |
| pri_i | input | N_SRC*PRI_W | Priority fields, lower value wins |
| ie_i | input | 1 | Global maskable-interrupt enable |
| ack_o | output | 1 | Acknowledge pulse |
| ack_src_o | output | $clog2(N_SRC) | Winning source during `ack_o` |
| flag_clr_o | output | N_SRC | One-hot clear for the winning flag |
| ie_clr_o | output | 1 | Clear request for the global enable |
| svc_valid_o | output | 1 | Save-and-vector request valid |
| svc_src_o | output | $clog2(N_SRC) | Source to vector to |
| svc_ready_i | input | 1 | Save logic accepts the request |

## Verification
A stuck or wrongly set hold bit shows up at the very next boundary. Either `ack_o` appears after a delaying class, or it is missing after an ordinary one. A missing break marker shows as an acknowledge instead of a lone `ie_clr_o` one cycle after the break retires. A corrupted service register shows as a wrong `svc_src_o` or a dropped transfer during a stalled handshake. The scoreboard catches this at the transfer itself. A busy flag that fails to clear shows at the next boundary as a missing acknowledge.

// File: rtl/irq_hold_pkg.sv
package irq_hold_pkg;
  typedef enum logic [3:0] {
    CLS_PLAIN      = 4'd0,
    CLS_PSW_WR     = 4'd1,
    CLS_RET_INT    = 4'd2,
    CLS_RET_BRK    = 4'd3,
    CLS_EN_INT     = 4'd4,
    CLS_DIS_INT    = 4'd5,
    CLS_SKIP       = 4'd6,
    CLS_IRQ_REG_WR = 4'd7,
    CLS_BREAK      = 4'd8
  } iclass_e;

  localparam int CLS_W = 4;
endpackage

// File: rtl/irq_class_decode.sv
module irq_class_decode
  import irq_hold_pkg::*;
(
  input  logic [CLS_W-1:0] cls_i,
  output logic             is_hold_o,
  output logic             is_break_o
);
  // Delaying classes and the break class; all other codes are ordinary (R2, R7, R11)
  always_comb begin
    is_hold_o  = 1'b0;
    is_break_o = 1'b0;
    case (cls_i)
      CLS_PSW_WR, CLS_RET_INT, CLS_RET_BRK, CLS_EN_INT,
      CLS_DIS_INT, CLS_SKIP, CLS_IRQ_REG_WR: is_hold_o  = 1'b1;
      CLS_BREAK:                             is_break_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_boundary_track.sv
module irq_boundary_track (
  input  logic clk,
  input  logic rst_n,
  input  logic retire_valid_i,
  input  logic is_hold_i,
  input  logic is_break_i,
  output logic bnd_o,
  output logic held_o,
  output logic brk_o
);
  // Boundary marker plus per-boundary hold and break state (R2, R3, R7, R10)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bnd_o  <= 1'b0;
      held_o <= 1'b0;
      brk_o  <= 1'b0;
    end else begin
      bnd_o <= retire_valid_i;
      if (retire_valid_i) begin
        held_o <= is_hold_i;
        brk_o  <= is_break_i;
      end
    end
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int N_SRC = 8,
  parameter int PRI_W = 2,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]       flags_i,
  input  logic [N_SRC-1:0]       mask_i,
  input  logic [N_SRC*PRI_W-1:0] pri_i,
  input  logic                   ie_i,
  output logic                   any_o,
  output logic [IDX_W-1:0]       win_o
);
  logic [N_SRC-1:0] elig;

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_elig
      assign elig[g] = flags_i[g] & ~mask_i[g] & ie_i;
    end
  endgenerate

  // Strict less-than keeps the lower index on equal priority (R5)
  always_comb begin
    logic [PRI_W-1:0] best;
    any_o = 1'b0;
    win_o = '0;
    best  = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!any_o || pri_i[i*PRI_W +: PRI_W] < best)) begin
        any_o = 1'b1;
        best  = pri_i[i*PRI_W +: PRI_W];
        win_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_svc_port.sv
module irq_svc_port #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant_i,
  input  logic [IDX_W-1:0] src_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] src_o
);
  // Request held until accepted; src is only loaded on a fresh grant (R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      src_o   <= '0;
    end else if (grant_i) begin
      valid_o <= 1'b1;
      src_o   <= src_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_ack_hold_ctrl.sv
module irq_ack_hold_ctrl
  import irq_hold_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int PRI_W = 2,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   retire_valid_i,
  input  logic [CLS_W-1:0]       retire_cls_i,
  input  logic [N_SRC-1:0]       flags_i,
  input  logic [N_SRC-1:0]       mask_i,
  input  logic [N_SRC*PRI_W-1:0] pri_i,
  input  logic                   ie_i,
  output logic                   ack_o,
  output logic [IDX_W-1:0]       ack_src_o,
  output logic [N_SRC-1:0]       flag_clr_o,
  output logic                   ie_clr_o,
  output logic                   svc_valid_o,
  output logic [IDX_W-1:0]       svc_src_o,
  input  logic                   svc_ready_i
);
  logic             is_hold, is_break;
  logic             bnd, held, brk;
  logic             any_elig;
  logic [IDX_W-1:0] win;
  logic             grant;

  irq_class_decode u_dec (
    .cls_i      (retire_cls_i),
    .is_hold_o  (is_hold),
    .is_break_o (is_break)
  );

  irq_boundary_track u_trk (
    .clk            (clk),
    .rst_n          (rst_n),
    .retire_valid_i (retire_valid_i),
    .is_hold_i      (is_hold),
    .is_break_i     (is_break),
    .bnd_o          (bnd),
    .held_o         (held),
    .brk_o          (brk)
  );

  irq_prio_arb #(.N_SRC(N_SRC), .PRI_W(PRI_W)) u_arb (
    .flags_i (flags_i),
    .mask_i  (mask_i),
    .pri_i   (pri_i),
    .ie_i    (ie_i),
    .any_o   (any_elig),
    .win_o   (win)
  );

  // Take a request only at an unheld, non-break boundary with the save port idle
  assign grant     = bnd & ~held & ~brk & ~svc_valid_o & any_elig;
  assign ack_o     = grant;
  assign ack_src_o = win;
  assign ie_clr_o  = grant | (bnd & brk);

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_clr
      assign flag_clr_o[g] = grant && (win == IDX_W'(g));
    end
  endgenerate

  irq_svc_port #(.IDX_W(IDX_W)) u_svc (
    .clk     (clk),
    .rst_n   (rst_n),
    .grant_i (grant),
    .src_i   (win),
    .ready_i (svc_ready_i),
    .valid_o (svc_valid_o),
    .src_o   (svc_src_o)
  );
endmodule

// File: rtl/irq_ack_hold_chk.sv
module irq_ack_hold_chk #(
  parameter int N_SRC = 8,
  parameter int PRI_W = 2,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   retire_valid_i,
  input logic [3:0]             retire_cls_i,
  input logic [N_SRC-1:0]       flags_i,
  input logic [N_SRC-1:0]       mask_i,
  input logic                   ie_i,
  input logic                   ack_o,
  input logic [IDX_W-1:0]       ack_src_o,
  input logic [N_SRC-1:0]       flag_clr_o,
  input logic                   ie_clr_o,
  input logic                   svc_valid_o,
  input logic [IDX_W-1:0]       svc_src_o,
  input logic                   svc_ready_i
);
  p_hold_blocks_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(retire_valid_i && retire_cls_i >= 4'd1 && retire_cls_i <= 4'd7) |-> !ack_o);

  p_ack_needs_elig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (flags_i[ack_src_o] && !mask_i[ack_src_o] && ie_i));

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> ($countones(flag_clr_o) == 1 && flag_clr_o[ack_src_o] && ie_clr_o));

  p_ack_only_at_bnd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(retire_valid_i));

  p_break_clears_ie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(retire_valid_i && retire_cls_i == 4'd8) |-> (ie_clr_o && !ack_o));

  p_svc_follows_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> (svc_valid_o && svc_src_o == $past(ack_src_o)));

  p_svc_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid_o && !svc_ready_i) |=> (svc_valid_o && $stable(svc_src_o)));

  p_busy_no_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid_o |-> !ack_o);
endmodule

bind irq_ack_hold_ctrl irq_ack_hold_chk #(.N_SRC(N_SRC), .PRI_W(PRI_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .retire_valid_i (retire_valid_i),
  .retire_cls_i   (retire_cls_i),
  .flags_i        (flags_i),
  .mask_i         (mask_i),
  .ie_i           (ie_i),
  .ack_o          (ack_o),
  .ack_src_o      (ack_src_o),
  .flag_clr_o     (flag_clr_o),
  .ie_clr_o       (ie_clr_o),
  .svc_valid_o    (svc_valid_o),
  .svc_src_o      (svc_src_o),
  .svc_ready_i    (svc_ready_i)
);

// File: tb/tb_irq_ack_hold_ctrl.sv
`timescale 1ns/1ps
module tb_irq_ack_hold_ctrl;
  localparam int N = 8;
  localparam int PW = 2;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          retire_valid = 1'b0;
  logic [3:0]    retire_cls = 4'd0;
  logic [N-1:0]  flags = '0;
  logic [N-1:0]  mask = '0;
  logic [N*PW-1:0] pri = '1;
  logic          ie = 1'b0;
  logic          ack, ie_clr, svc_valid, svc_ready = 1'b1;
  logic [IW-1:0] ack_src, svc_src;
  logic [N-1:0]  flag_clr;

  int total = 0;
  int bad = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  irq_ack_hold_ctrl #(.N_SRC(N), .PRI_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .retire_valid_i(retire_valid), .retire_cls_i(retire_cls),
    .flags_i(flags), .mask_i(mask), .pri_i(pri), .ie_i(ie),
    .ack_o(ack), .ack_src_o(ack_src), .flag_clr_o(flag_clr), .ie_clr_o(ie_clr),
    .svc_valid_o(svc_valid), .svc_src_o(svc_src), .svc_ready_i(svc_ready)
  );

  // External flag / enable registers apply the clears at the edge
  always @(posedge clk) begin
    if (rst_n) begin
      flags <= flags & ~flag_clr;
      if (ie_clr) ie <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each completed save transfer (R8)
  always @(negedge clk) begin
    if (rst_n && svc_valid && svc_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected transfer", svc_src, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(svc_src == IW'(e), "R8 transfer source", svc_src, e);
      end
    end
  end

  // Driver: one retire, then check the boundary cycle
  task automatic retire(input logic [3:0] cls, input bit exp_ack, input int exp_src,
                        input string req);
    @(negedge clk);
    retire_valid = 1'b1;
    retire_cls = cls;
    @(negedge clk);
    retire_valid = 1'b0;
    chk(ack == exp_ack, req, ack, exp_ack);
    if (exp_ack) begin
      chk(ack_src == IW'(exp_src), {req, " src"}, ack_src, exp_src);
      chk(flag_clr == (N'(1) << exp_src) && ie_clr, {req, " R6 clears"}, flag_clr, 1 << exp_src);
      exp_q.push_back(exp_src);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setf(input int i);
    @(negedge clk);
    flags[i] = 1'b1;
    ie = 1'b1;
  endtask

  initial begin : watchdog
    #200000;
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    chk(!ack && !ie_clr && !svc_valid && flag_clr == '0, "R1 reset outputs", ack, 0);
    rst_n = 1'b1;
    idle(2);
    @(negedge clk); ie = 1'b1;
    retire(4'd0, 1'b0, 0, "R4 no flags");
    setf(3);
    retire(4'd0, 1'b1, 3, "R1 first boundary unheld / R6 ack");
    idle(3);

    // R4 eligibility
    @(negedge clk); flags[2] = 1'b1; mask[2] = 1'b1; ie = 1'b1;
    retire(4'd0, 1'b0, 0, "R4 masked");
    @(negedge clk); mask[2] = 1'b0; ie = 1'b0;
    retire(4'd0, 1'b0, 0, "R4 enable off");
    @(negedge clk); ie = 1'b1;
    retire(4'd0, 1'b1, 2, "R4 eligible");
    idle(3);

    // R2 each delaying class, R3 next ordinary takes it
    for (int c = 1; c <= 7; c++) begin
      setf(5);
      retire(4'(c), 1'b0, 0, "R2 delaying class");
      retire(4'd0, 1'b1, 5, "R3 after delaying class");
      idle(3);
    end

    // R3 back-to-back holds
    setf(1);
    retire(4'd6, 1'b0, 0, "R3 hold 1");
    retire(4'd1, 1'b0, 0, "R3 hold 2");
    retire(4'd7, 1'b0, 0, "R3 hold 3");
    retire(4'd0, 1'b1, 1, "R3 released");
    idle(3);

    // R9 request arrives during hold
    @(negedge clk); ie = 1'b1;
    retire(4'd4, 1'b0, 0, "R9 hold no request");
    setf(7);
    retire(4'd0, 1'b1, 7, "R9 pending taken");
    idle(3);

    // R5 arbitration
    @(negedge clk);
    pri = '1;
    pri[0*PW +: PW] = 2'd2; pri[4*PW +: PW] = 2'd1; pri[6*PW +: PW] = 2'd1;
    flags[0] = 1'b1; flags[4] = 1'b1; flags[6] = 1'b1; ie = 1'b1;
    retire(4'd0, 1'b1, 4, "R5 lowest value, lower index on tie");
    idle(3); @(negedge clk); ie = 1'b1;
    retire(4'd0, 1'b1, 6, "R5 tie loser next");
    idle(3); @(negedge clk); ie = 1'b1;
    retire(4'd0, 1'b1, 0, "R5 last");
    idle(3);
    @(negedge clk); pri = '1;

    // R7 break
    setf(2);
    @(negedge clk); retire_valid = 1'b1; retire_cls = 4'd8;
    @(negedge clk); retire_valid = 1'b0;
    chk(!ack, "R7 no ack at break", ack, 0);
    chk(ie_clr, "R7 enable clear", ie_clr, 1);
    retire(4'd0, 1'b0, 0, "R7 enable now off");
    @(negedge clk); ie = 1'b1;
    retire(4'd0, 1'b1, 2, "R7 break not delaying");
    idle(3);

    // R8 back-pressure
    @(negedge clk); svc_ready = 1'b0;
    setf(3);
    retire(4'd0, 1'b1, 3, "R8 ack stalled");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(svc_valid && svc_src == 3'd3, "R8 held stable", svc_src, 3);
    end
    setf(5);
    retire(4'd0, 1'b0, 0, "R8 busy blocks ack");
    @(negedge clk); svc_ready = 1'b1;
    idle(2);
    retire(4'd0, 1'b1, 5, "R8 ack after drain");
    idle(3);

    // R10 no retire, no boundary
    setf(6);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!ack, "R10 no boundary", ack, 0);
    end
    retire(4'd12, 1'b1, 6, "R11 code 12 ordinary");
    idle(3);
    setf(0);
    retire(4'd15, 1'b1, 0, "R11 code 15 ordinary");
    idle(4);

    chk(exp_q.size() == 0, "R8 all transfers seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule